// File: doc/BRIEF.md
# Programmable Configuration Startup Sequencer

This block carries a device from configuration mode into user mode by stepping a phase counter from 0 up to a terminal phase of 7. Each step is triggered by a tick from one of three startup clock sources: the configuration clock, a user clock or the JTAG TCK. All logic runs on one system clock, and each source arrives as a single-cycle tick strobe. Three events each have their own programmable phase: driving the DONE output high, asserting global write-enable (GWE), and releasing the global three-state hold on the I/O (GTS release). GWE and GTS release can instead wait for the DONE pin level seen from outside. They can also be left untouched, which suits partial reconfiguration.

One phase can be set as a stall point. The counter holds at that phase until every clock manager flagged in the wait mask reports lock. All pins are plain control and status levels. There is no streaming interface, so there is no valid/ready handshake and no back-pressure. Every event output is sticky until a synchronous reset.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (`done_drive`, `gwe`, `gts_release`, `eos`) go low and the sequencer returns to idle.
- R2: A `start_req` pulse from idle places the counter at phase 0. From there each accepted tick moves it up by exactly one phase. It stops at phase 7, and `eos` is then high from the following cycle.
- R3: `tick_src` selects the advancing tick: 0 selects the configuration tick, 1 the user tick, 2 the JTAG tick and 3 the configuration tick. Ticks on unselected sources have no effect on the phase.
- R4: `done_drive` goes high one cycle after the phase first reaches `done_sel` (values 1 to 6). The values 0 and 7 behave as 6.
- R5: When `gwe_sel` is 1 to 6, `gwe` goes high one cycle after the phase first reaches that value.
- R6: When `gts_sel` is 1 to 6, `gts_release` goes high one cycle after the phase first reaches that value.
- R7: A select value of 0 on `gwe_sel` or `gts_sel` ignores the phase. The output then rises only after a started sequence sees `done_pin_in` high through a two-flop synchronizer, which takes at least three clock edges after the pin rises.
- R8: A select value of 7 on `gwe_sel` or `gts_sel` keeps that output at its current value for the whole sequence.
- R9: `lock_sel` values 0 to 6 mark a stall phase, and 7 disables waiting. At the stall phase the counter ignores ticks while any bit set in `lock_wait_mask` has its `lock_ok` bit low.
- R10: Once high, `done_drive`, `gwe` and `gts_release` stay high until reset, even if `done_pin_in` falls again.
- R11: `start_req` while a sequence is already running or finished is ignored. The phase does not restart and `eos` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Begin sequence from idle |
| tick_src | input | 2 | Advancing tick source select |
| tick_cfg | input | 1 | Configuration clock tick strobe |
| tick_user | input | 1 | User clock tick strobe |
| tick_jtag | input | 1 | JTAG TCK tick strobe |
| done_sel | input | 3 | Phase that drives DONE high |
| gwe_sel | input | 3 | GWE phase, 0 = wait DONE pin, 7 = keep |
| gts_sel | input | 3 | GTS release phase, 0 = wait DONE pin, 7 = keep |
| lock_sel | input | 3 | Lock stall phase, 7 = no wait |
| lock_wait_mask | input | NUM_CM | Clock managers to wait on |
| lock_ok | input | NUM_CM | Lock indications |
| done_pin_in | input | 1 | Sampled external DONE pin level |
| done_drive | output | 1 | Drive DONE high |
| gwe | output | 1 | Global write-enable |
| gts_release | output | 1 | Global three-state released |
| eos | output | 1 | End of startup |

## Verification
The bench targets the odd select codes: 0 and 7 on `done_sel` must act as phase 6, while on `gwe_sel` and `gts_sel` they mean "wait for DONE" and "keep". A design that mixed these up would fire GWE at a phase instead of waiting, or release the I/O early. Ticks from unselected sources are mixed into every run, so a design with a wrong tick select would advance too far. Stall phases are tried with masks partly locked, so a design that ignored the mask or stalled at the wrong phase would show a different DONE and end timing. The DONE pin is dropped after it rises and a late start request is sent, so a design without sticky outputs or one that restarts would lose GWE or `eos`. A directed case checks that GWE does not rise before the synchronizer delay.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  localparam int PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PHASE_END      = '1;
  localparam phase_t SEL_WAIT_DONE  = '0;
  localparam phase_t SEL_HOLD       = '1;
  localparam phase_t LAST_EVT_PHASE = PHASE_END - phase_t'(1);

  typedef enum logic [1:0] {
    TSRC_CFG  = 2'd0,
    TSRC_USER = 2'd1,
    TSRC_JTAG = 2'd2,
    TSRC_CFG2 = 2'd3
  } tick_src_e;

  // Fixed-phase-only events treat the out-of-range codes as the last event phase.
  function automatic phase_t clamp_fixed_sel(input phase_t s);
    if (s == SEL_WAIT_DONE || s == SEL_HOLD) return LAST_EVT_PHASE;
    return s;
  endfunction
endpackage

// File: rtl/startup_tick_mux.sv
module startup_tick_mux
  import startup_seq_pkg::*;
(
  input  tick_src_e sel,
  input  logic      tick_cfg,
  input  logic      tick_user,
  input  logic      tick_jtag,
  output logic      tick
);
  always_comb begin
    unique case (sel)
      TSRC_CFG:  tick = tick_cfg;
      TSRC_USER: tick = tick_user;
      TSRC_JTAG: tick = tick_jtag;
      TSRC_CFG2: tick = tick_cfg;
    endcase
  end
endmodule

// File: rtl/startup_sync.sv
module startup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr
  import startup_seq_pkg::*;
#(
  parameter int NUM_CM = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              tick,
  input  phase_t            lock_sel,
  input  logic [NUM_CM-1:0] lock_wait_mask,
  input  logic [NUM_CM-1:0] lock_ok,
  output logic              started,
  output phase_t            phase,
  output logic              stall,
  output logic              eos
);
  logic pending_lock;
  logic advance;

  assign pending_lock = |(lock_wait_mask & ~lock_ok);
  assign stall   = started && (lock_sel != SEL_HOLD) && (phase == lock_sel) && pending_lock;
  assign advance = started && tick && (phase != PHASE_END) && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      phase   <= '0;
      eos     <= 1'b0;
    end else begin
      if (!started && start_req) begin
        started <= 1'b1;
        phase   <= '0;
      end else if (advance) begin
        phase <= phase + phase_t'(1);
      end
      eos <= started && (phase == PHASE_END);
    end
  end
endmodule

// File: rtl/startup_event.sv
module startup_event
  import startup_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   started,
  input  phase_t phase,
  input  phase_t sel,
  input  logic   done_seen,
  output logic   evt
);
  logic keep;
  logic hit;

  always_comb begin
    keep = 1'b0;
    hit  = 1'b0;
    if (sel == SEL_HOLD)           keep = 1'b1;
    else if (sel == SEL_WAIT_DONE) hit  = done_seen;
    else                           hit  = (phase >= sel);
  end

  always_ff @(posedge clk) begin
    if (rst)                         evt <= 1'b0;
    else if (!keep && started && hit) evt <= 1'b1;
  end
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_seq_pkg::*;
#(
  parameter int NUM_CM      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [1:0]        tick_src,
  input  logic              tick_cfg,
  input  logic              tick_user,
  input  logic              tick_jtag,
  input  logic [2:0]        done_sel,
  input  logic [2:0]        gwe_sel,
  input  logic [2:0]        gts_sel,
  input  logic [2:0]        lock_sel,
  input  logic [NUM_CM-1:0] lock_wait_mask,
  input  logic [NUM_CM-1:0] lock_ok,
  input  logic              done_pin_in,
  output logic              done_drive,
  output logic              gwe,
  output logic              gts_release,
  output logic              eos
);
  logic   tick;
  logic   started;
  phase_t phase;
  logic   stall;
  logic   done_sync;
  phase_t done_sel_eff;

  assign done_sel_eff = clamp_fixed_sel(phase_t'(done_sel));

  startup_tick_mux u_tick (
    .sel       (tick_src_e'(tick_src)),
    .tick_cfg  (tick_cfg),
    .tick_user (tick_user),
    .tick_jtag (tick_jtag),
    .tick      (tick)
  );

  startup_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk (clk),
    .rst (rst),
    .d   (done_pin_in),
    .q   (done_sync)
  );

  startup_phase_ctr #(.NUM_CM(NUM_CM)) u_ctr (
    .clk            (clk),
    .rst            (rst),
    .start_req      (start_req),
    .tick           (tick),
    .lock_sel       (phase_t'(lock_sel)),
    .lock_wait_mask (lock_wait_mask),
    .lock_ok        (lock_ok),
    .started        (started),
    .phase          (phase),
    .stall          (stall),
    .eos            (eos)
  );

  startup_event u_done_evt (
    .clk       (clk),
    .rst       (rst),
    .started   (started),
    .phase     (phase),
    .sel       (done_sel_eff),
    .done_seen (done_sync),
    .evt       (done_drive)
  );

  startup_event u_gwe_evt (
    .clk       (clk),
    .rst       (rst),
    .started   (started),
    .phase     (phase),
    .sel       (phase_t'(gwe_sel)),
    .done_seen (done_sync),
    .evt       (gwe)
  );

  startup_event u_gts_evt (
    .clk       (clk),
    .rst       (rst),
    .started   (started),
    .phase     (phase),
    .sel       (phase_t'(gts_sel)),
    .done_seen (done_sync),
    .evt       (gts_release)
  );
endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] gwe_sel,
  input logic [2:0] phase,
  input logic       stall,
  input logic       done_sync,
  input logic       done_drive,
  input logic       gwe,
  input logic       gts_release,
  input logic       eos
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!done_drive && !gwe && !gts_release && !eos));

  a_r2_phase_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == $past(phase) || phase == $past(phase) + 3'd1));

  a_r2_eos_at_end: assert property (@(posedge clk) disable iff (rst)
    eos |-> (phase == 3'd7));

  a_r4_eos_after_done: assert property (@(posedge clk) disable iff (rst)
    eos |-> done_drive);

  a_r7_wait_done_needs_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(gwe) |-> ($past(gwe_sel) != 3'd0 || $past(done_sync)));

  a_r8_keep_holds_low: assert property (@(posedge clk) disable iff (rst)
    (gwe_sel == 3'd7 && !gwe) |=> !gwe);

  a_r9_stall_holds_phase: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(phase));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_drive |=> done_drive);

  a_r10_gwe_sticky: assert property (@(posedge clk) disable iff (rst)
    gwe |=> gwe);

  a_r10_gts_sticky: assert property (@(posedge clk) disable iff (rst)
    gts_release |=> gts_release);
endmodule

bind startup_sequencer startup_sequencer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .gwe_sel     (gwe_sel),
  .phase       (phase),
  .stall       (stall),
  .done_sync   (done_sync),
  .done_drive  (done_drive),
  .gwe         (gwe),
  .gts_release (gts_release),
  .eos         (eos)
);

// File: tb/startup_sequencer_tb_top.sv
module startup_sequencer_tb_top;
  localparam int NCM = 4;

  logic clk = 1'b0;
  logic rst, start_req, tick_cfg, tick_user, tick_jtag, done_pin_in;
  logic [1:0] tick_src;
  logic [2:0] done_sel, gwe_sel, gts_sel, lock_sel;
  logic [NCM-1:0] lock_wait_mask, lock_ok;
  logic done_drive, gwe, gts_release, eos;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  startup_sequencer #(.NUM_CM(NCM)) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .tick_src(tick_src),
    .tick_cfg(tick_cfg), .tick_user(tick_user), .tick_jtag(tick_jtag),
    .done_sel(done_sel), .gwe_sel(gwe_sel), .gts_sel(gts_sel),
    .lock_sel(lock_sel), .lock_wait_mask(lock_wait_mask), .lock_ok(lock_ok),
    .done_pin_in(done_pin_in), .done_drive(done_drive), .gwe(gwe),
    .gts_release(gts_release), .eos(eos)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit exp_done(input int sel, input int ph);
    int thr = (sel == 0 || sel == 7) ? 6 : sel;
    return ph >= thr;
  endfunction

  function automatic bit exp_mode_evt(input int sel, input int ph, input bit pin_seen);
    if (sel == 7) return 1'b0;
    if (sel == 0) return pin_seen;
    return ph >= sel;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_req = 1'b0; tick_cfg = 1'b0; tick_user = 1'b0;
    tick_jtag = 1'b0; done_pin_in = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_random(input int iter);
    int src, ph;
    bit pin_seen;
    int pin_at;
    tick_src = 2'($urandom % 4);
    done_sel = 3'($urandom % 8);
    gwe_sel  = 3'($urandom % 8);
    gts_sel  = 3'($urandom % 8);
    lock_sel = 3'($urandom % 8);
    lock_wait_mask = NCM'($urandom);
    lock_ok = NCM'($urandom);
    pin_at = $urandom % 14;
    do_reset();
    if (iter == 0) begin
      chk("R1 done_drive after reset", done_drive, 1'b0);
      chk("R1 gwe after reset", gwe, 1'b0);
      chk("R1 gts_release after reset", gts_release, 1'b0);
      chk("R1 eos after reset", eos, 1'b0);
    end
    src = (tick_src == 2'd3) ? 0 : int'(tick_src);
    pulse_start();
    ph = 0;
    pin_seen = 1'b0;
    for (int t = 0; t < 14; t++) begin
      int s;
      bit stalled;
      if (t == pin_at) begin done_pin_in = 1'b1; pin_seen = 1'b1; end
      if (t == pin_at + 2) done_pin_in = 1'b0;   // R10: pin drop must not clear
      if (t == 9) lock_ok = '1;
      s = $urandom % 3;
      tick_cfg = (s == 0); tick_user = (s == 1); tick_jtag = (s == 2);
      stalled = (lock_sel != 3'd7) && (ph == int'(lock_sel)) &&
                ((lock_wait_mask & ~lock_ok) != '0);
      if (s == src && ph < 7 && !stalled) ph++;
      @(negedge clk);
      tick_cfg = 1'b0; tick_user = 1'b0; tick_jtag = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 R3 R9 eos vs phase", eos, ph == 7);
      chk("R4 done_drive", done_drive, exp_done(int'(done_sel), ph));
      chk("R5 R7 R8 R10 gwe", gwe, exp_mode_evt(int'(gwe_sel), ph, pin_seen));
      chk("R6 R7 R8 R10 gts_release", gts_release, exp_mode_evt(int'(gts_sel), ph, pin_seen));
    end
    // R11: late start request must not restart the sequence
    pulse_start();
    chk("R11 eos after late start", eos, ph == 7);
    chk("R11 done_drive after late start", done_drive, exp_done(int'(done_sel), ph));
    // R1: reset mid-state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 done_drive cleared", done_drive, 1'b0);
    chk("R1 gwe cleared", gwe, 1'b0);
    chk("R1 eos cleared", eos, 1'b0);
  endtask

  task automatic directed_sync();
    tick_src = 2'd0; done_sel = 3'd6; gwe_sel = 3'd0; gts_sel = 3'd0;
    lock_sel = 3'd7; lock_wait_mask = '0; lock_ok = '0;
    do_reset();
    pulse_start();
    done_pin_in = 1'b1;
    @(negedge clk);
    chk("R7 gwe not before sync delay", gwe, 1'b0);
    @(negedge clk);
    chk("R7 gts_release not before sync delay", gts_release, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7 gwe after sync delay", gwe, 1'b1);
    chk("R7 gts_release after sync delay", gts_release, 1'b1);
  endtask

  task automatic directed_stall();
    tick_src = 2'd1; done_sel = 3'd1; gwe_sel = 3'd7; gts_sel = 3'd2;
    lock_sel = 3'd0; lock_wait_mask = 4'b0101; lock_ok = 4'b0100;
    do_reset();
    pulse_start();
    for (int i = 0; i < 3; i++) begin
      tick_user = 1'b1;
      @(negedge clk);
      tick_user = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R9 no advance while unlocked", done_drive, 1'b0);
    lock_ok = 4'b0101;
    tick_user = 1'b1;
    @(negedge clk);
    tick_user = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 advance after lock", done_drive, 1'b1);
    chk("R8 keep holds gwe", gwe, 1'b0);
    tick_cfg = 1'b1;
    @(negedge clk);
    tick_cfg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 unselected tick ignored", gts_release, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1'b1; start_req = 1'b0; tick_cfg = 1'b0; tick_user = 1'b0;
    tick_jtag = 1'b0; done_pin_in = 1'b0; tick_src = 2'd0;
    done_sel = 3'd1; gwe_sel = 3'd1; gts_sel = 3'd1; lock_sel = 3'd7;
    lock_wait_mask = '0; lock_ok = '0;
    directed_sync();
    directed_stall();
    for (int i = 0; i < 40; i++) run_random(i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule